// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider Controller

This block sits behind an external dual-modulus prescaler and is clocked by the prescaler's output. It counts prescaler output periods in frames of M periods. For the first A periods of each frame it asks for the larger modulus (N+1) on a registered modulus-control line, and for the rest of the frame it asks for N. The whole frame spans M·N + A input cycles of the prescaler. At the last period of each frame it raises a one-period divided output pulse that goes on to the phase comparator.

Two frequency words are held outside the block, and a select input picks the active one. The block samples the selected word, the select input and the modulus mode only when a new frame starts. A change made in the middle of a frame therefore never disturbs the frame in progress, and the synthesiser can be toggled between two frequencies without glitches. The mode bit picks 16/17 operation (N = 16, 4-bit A) or 8/9 operation (N = 8, 3-bit A). A word whose M is below the mode's minimum, or whose M is smaller than its A, is refused. While it is refused, both outputs are held low and an error flag is raised.

Top module: `swallow_divider`

## Requirements
- R1: While rst is high and on the first clock after it, mod_ctl, div_out and word_err are all low.
- R2: With a valid word, div_out is high for exactly one clock in every M clocks, and that clock is the last one of the frame.
- R3: In every frame, mod_ctl is high for exactly the first A clocks and low for the remaining M−A clocks. With A = 0 it never rises.
- R4: The prescaler input cycles per frame, counted as N per clock with mod_ctl low and N+1 per clock with mod_ctl high, total M·N + A. N is 16 when narrow_mode = 0 and 8 when narrow_mode = 1. This holds at the minimum word of each mode.
- R5: When narrow_mode = 1, only bits [2:0] of the swallow value are used and bit 3 is ignored.
- R6: word contents, sel_b and narrow_mode are sampled only at the clock edge that starts a frame. Changes during a frame affect neither that frame's length nor its mod_ctl pattern.
- R7: sel_b = 0 selects word 0 and sel_b = 1 selects word 1 for the next frame.
- R8: A word is refused when M < 16 (with narrow_mode = 0), when M < 7 (with narrow_mode = 1), or when M < A. While a word is refused, word_err is high and mod_ctl and div_out stay low. The word is re-sampled on every clock, and a new frame starts on the edge at which a valid word is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_mode | input | 1 | 0: 16/17 operation, 1: 8/9 operation |
| sel_b | input | 1 | Active word select, 1 picks word 1 |
| word0_swallow | input | AW (4) | Word 0 swallow count A |
| word0_main | input | MW (15) | Word 0 main count M |
| word1_swallow | input | AW (4) | Word 1 swallow count A |
| word1_main | input | MW (15) | Word 1 main count M |
| mod_ctl | output | 1 | Modulus control, high requests N+1 |
| div_out | output | 1 | One-clock pulse at the end of each frame |
| word_err | output | 1 | Sampled word refused |

## Verification
A corrupted main counter shows up at the first frame boundary: the divided pulse lands early or late, so the frame length measured between pulses differs from M. A wrong swallow count shows up within one frame as the wrong number of high mod_ctl clocks, or as high clocks that do not form one run at the start of the frame. A sampling fault shows up one frame after a mid-frame change, as a frame built from the scrambled values. A refused word must show word_err on the clock after the boundary, with both outputs low.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned SWC_AW_DEF = 4;
  localparam int unsigned SWC_MW_DEF = 15;
  typedef enum logic { PM_WIDE = 1'b0, PM_NARROW = 1'b1 } pmode_e;
endpackage

// File: rtl/swc_word_pick.sv
module swc_word_pick #(
  parameter int unsigned AW = 4,
  parameter int unsigned MW = 15,
  parameter int unsigned MIN_M_WIDE = 16,
  parameter int unsigned MIN_M_NARROW = 7
) (
  input  logic [AW-1:0] a0_i,
  input  logic [MW-1:0] m0_i,
  input  logic [AW-1:0] a1_i,
  input  logic [MW-1:0] m1_i,
  input  logic          sel_b_i,
  input  swc_pkg::pmode_e mode_i,
  output logic [AW-1:0] a_o,
  output logic [MW-1:0] m_o,
  output logic          ok_o
);
  logic [AW-1:0] a_raw;
  logic [MW-1:0] m_floor;

  always_comb begin
    a_raw = sel_b_i ? a1_i : a0_i;
    m_o   = sel_b_i ? m1_i : m0_i;
    if (mode_i == swc_pkg::PM_NARROW) begin
      a_o     = {1'b0, a_raw[AW-2:0]};
      m_floor = MW'(MIN_M_NARROW);
    end else begin
      a_o     = a_raw;
      m_floor = MW'(MIN_M_WIDE);
    end
    ok_o = (m_o >= m_floor) && (m_o >= {{(MW-AW){1'b0}}, a_o});
  end
endmodule

// File: rtl/swc_main_ctr.sv
module swc_main_ctr #(
  parameter int unsigned MW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ok_i,
  input  logic [MW-1:0] m_i,
  output logic          bound_o,
  output logic          div_o,
  output logic          err_o
);
  logic [MW-1:0] left_q;

  assign bound_o = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      div_o  <= 1'b0;
      err_o  <= 1'b0;
    end else if (bound_o) begin
      div_o <= 1'b0;
      if (ok_i) begin
        left_q <= m_i - 1'b1;
        err_o  <= 1'b0;
      end else begin
        err_o <= 1'b1;
      end
    end else begin
      left_q <= left_q - 1'b1;
      div_o  <= (left_q == MW'(1));
    end
  end

  AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (rst)
    div_o |-> bound_o); // R2
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    div_o |=> !div_o); // R2
endmodule

// File: rtl/swc_swallow_ctr.sv
module swc_swallow_ctr #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bound_i,
  input  logic          ok_i,
  input  logic [AW-1:0] a_i,
  output logic          mod_o
);
  logic [AW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      mod_o <= 1'b0;
    end else if (bound_i) begin
      rem_q <= ok_i ? a_i : '0;
      mod_o <= ok_i && (a_i != '0);
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
      mod_o <= (rem_q > AW'(1));
    end else begin
      mod_o <= 1'b0;
    end
  end

  AST_MOD_NO_RERISE: assert property (@(posedge clk) disable iff (rst)
    (!bound_i && !mod_o) |=> !mod_o); // R3
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int unsigned AW = swc_pkg::SWC_AW_DEF,
  parameter int unsigned MW = swc_pkg::SWC_MW_DEF,
  parameter int unsigned MIN_M_WIDE = 16,
  parameter int unsigned MIN_M_NARROW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow_mode,
  input  logic          sel_b,
  input  logic [AW-1:0] word0_swallow,
  input  logic [MW-1:0] word0_main,
  input  logic [AW-1:0] word1_swallow,
  input  logic [MW-1:0] word1_main,
  output logic          mod_ctl,
  output logic          div_out,
  output logic          word_err
);
  swc_pkg::pmode_e mode;
  logic [AW-1:0]   a_sel;
  logic [MW-1:0]   m_sel;
  logic            word_ok;
  logic            at_bound;

  assign mode = narrow_mode ? swc_pkg::PM_NARROW : swc_pkg::PM_WIDE;

  swc_word_pick #(.AW(AW), .MW(MW), .MIN_M_WIDE(MIN_M_WIDE),
                  .MIN_M_NARROW(MIN_M_NARROW)) u_pick (
    .a0_i(word0_swallow), .m0_i(word0_main),
    .a1_i(word1_swallow), .m1_i(word1_main),
    .sel_b_i(sel_b), .mode_i(mode),
    .a_o(a_sel), .m_o(m_sel), .ok_o(word_ok)
  );

  swc_main_ctr #(.MW(MW)) u_main (
    .clk(clk), .rst(rst), .ok_i(word_ok), .m_i(m_sel),
    .bound_o(at_bound), .div_o(div_out), .err_o(word_err)
  );

  swc_swallow_ctr #(.AW(AW)) u_swal (
    .clk(clk), .rst(rst), .bound_i(at_bound), .ok_i(word_ok),
    .a_i(a_sel), .mod_o(mod_ctl)
  );

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    word_err |-> (!div_out && !mod_ctl)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!div_out && !mod_ctl && !word_err)); // R1
endmodule

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int MW = 15;

  typedef struct {
    int m;
    int a;
    int n;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic narrow_mode = 1'b0;
  logic sel_b = 1'b0;
  logic [AW-1:0] word0_swallow = '0;
  logic [MW-1:0] word0_main = '0;
  logic [AW-1:0] word1_swallow = '0;
  logic [MW-1:0] word1_main = '0;
  logic mod_ctl, div_out, word_err;

  exp_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rst(rst), .narrow_mode(narrow_mode), .sel_b(sel_b),
    .word0_swallow(word0_swallow), .word0_main(word0_main),
    .word1_swallow(word1_swallow), .word1_main(word1_main),
    .mod_ctl(mod_ctl), .div_out(div_out), .word_err(word_err)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_a(input bit nar, input int a);
    return nar ? (a % 8) : a;
  endfunction

  // Driver: sets the active word so that it is present at the next frame edge.
  task automatic apply(input bit wait_end, input bit nar, input bit sel,
                       input int a, input int m, input bit push_it,
                       input bit scramble, input string tag);
    exp_t e;
    if (wait_end) begin
      do @(negedge clk); while (!div_out);
    end else begin
      @(negedge clk);
    end
    narrow_mode = nar;
    sel_b = sel;
    if (sel) begin
      word1_swallow = AW'(a); word1_main = MW'(m);
    end else begin
      word0_swallow = AW'(a); word0_main = MW'(m);
    end
    if (push_it) begin
      e.m = m; e.a = eff_a(nar, a); e.n = nar ? 8 : 16; e.tag = tag;
      sb.push_back(e);
    end
    if (scramble) begin
      repeat (3) @(negedge clk);
      narrow_mode = ~nar;
      sel_b = ~sel;
      word0_swallow = 4'd9;  word0_main = 15'd5;
      word1_swallow = 4'd11; word1_main = 15'd40;
    end
  endtask

  // Monitor: measures each frame and compares against the queue head.
  initial begin
    int cyc = 0;
    int hi = 0;
    bit split = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst || word_err) begin
        cyc = 0; hi = 0; split = 1'b0;
      end else begin
        if (mod_ctl) begin
          if (hi != cyc) split = 1'b1;
          hi++;
        end
        cyc++;
        if (div_out) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R2 unexpected pulse", cyc, 0);
          end else begin
            e = sb.pop_front();
            chk(cyc == e.m, {"R2 frame length ", e.tag}, cyc, e.m);
            chk(hi == e.a, {"R3 high clocks ", e.tag}, hi, e.a);
            chk(!split, {"R3 high run at frame start ", e.tag}, int'(split), 0);
            chk(cyc * e.n + hi == e.m * e.n + e.a, {"R4 ratio ", e.tag},
                cyc * e.n + hi, e.m * e.n + e.a);
          end
          cyc = 0; hi = 0; split = 1'b0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    word0_swallow = 4'd5; word0_main = 15'd20;
    repeat (3) @(negedge clk);
    chk(!mod_ctl && !div_out && !word_err, "R1 outputs during reset",
        {29'd0, mod_ctl, div_out, word_err}, 0);
    begin
      exp_t e0;
      e0.m = 20; e0.a = 5; e0.n = 16; e0.tag = "R2 base";
      sb.push_back(e0);
    end
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!div_out && !word_err, "R1 first clock after reset",
        {30'd0, div_out, word_err}, 0);

    // R6 mid-frame scramble must not touch the running frame
    apply(1, 0, 0, 5, 20, 1, 1, "R6 scrambled mid-frame");
    apply(1, 0, 0, 9, 40, 1, 0, "R6 next frame");
    // R3 zero swallow, R7 word 1
    apply(1, 0, 1, 0, 25, 1, 0, "R3 A=0 R7 word1");
    apply(1, 0, 0, 15, 16, 1, 0, "R4 wide minimum R7 word0");
    apply(1, 0, 1, 12, 33, 1, 1, "R7 word1 with R6 scramble");
    apply(1, 0, 0, 3, 21, 1, 0, "R7 back to word0");
    // narrow mode
    apply(1, 1, 0, 7, 7, 1, 0, "R4 narrow minimum");
    apply(1, 1, 1, 15, 10, 1, 0, "R5 bit3 ignored");
    apply(1, 1, 0, 9, 12, 1, 0, "R5 A=9 acts as 1");

    // R8 narrow M below minimum
    apply(1, 1, 0, 2, 6, 0, 0, "R8");
    repeat (4) begin
      @(negedge clk);
      chk(word_err, "R8 err raised narrow", int'(word_err), 1);
      chk(!mod_ctl && !div_out, "R8 outputs held narrow",
          {30'd0, mod_ctl, div_out}, 0);
    end
    apply(0, 1, 0, 3, 9, 1, 0, "R8 recovery narrow");
    @(negedge clk);
    chk(!word_err, "R8 err cleared", int'(word_err), 0);

    // R8 wide M below minimum
    apply(1, 0, 1, 2, 15, 0, 0, "R8");
    repeat (3) begin
      @(negedge clk);
      chk(word_err, "R8 err raised wide", int'(word_err), 1);
      chk(!mod_ctl && !div_out, "R8 outputs held wide",
          {30'd0, mod_ctl, div_out}, 0);
    end
    apply(0, 0, 1, 8, 18, 1, 1, "R8 recovery wide R6");
    apply(1, 0, 0, 4, 20, 1, 0, "R6 after scramble");
    apply(1, 0, 0, 4, 20, 1, 0, "R2 repeat");

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule